// File: doc/BRIEF.md
# String Load/Store/Move Engine

This block is a small sequencer that carries out single string operations for a processor core. It owns three 32-bit registers: a source index, a destination index and an accumulator. It accepts one command at a time. A command gives an operation (load, store or move), an element size (1, 2 or 4 bytes) and a direction. The engine performs the memory read, the memory write, or both, through a request/acknowledge port with byte enables. It then steps the index registers it used by the element size, up or down.

The linear address is the sum of a segment base and an index. Two base inputs are supplied from outside: a data base and an extra base. Loads and stores address through the data base. A move reads through the data base and writes through the extra base. A preset strobe loads the three registers while the engine is idle, and the registers are always visible on outputs. Repeat counting, segment loading and fault handling are not part of the block.

On the memory port an element is carried right-aligned: byte 0 of the element is on data bits 7:0. `mem_be` marks the valid low bytes. A request is held until `mem_ack`. Read data is taken in the cycle where `mem_ack` is high.

Top module: `strop_engine`

## Requirements
- R1: While `rst_n` is low and after it rises, `si_q`, `di_q`, `acc_q` are 0 and `busy`, `done`, `mem_req` are 0.
- R2: A load (`cmd_op`=0) issues one read at `ds_base + si`, with `mem_we`=0 and `mem_be` equal to 4'b0001, 4'b0011 or 4'b1111 for `cmd_size` 0, 1 or 2. Only the low 1, 2 or 4 bytes of the accumulator take the read data (from `mem_rdata` bits 7:0 upward); the other bytes keep their old value.
- R3: A store (`cmd_op`=1) issues one write at `ds_base + di`, with `mem_we`=1 and the same byte-enable encoding as R2. `mem_wdata` carries the low element bytes of the accumulator, and every byte above the element is zero. The accumulator is unchanged.
- R4: A move (`cmd_op`=2) first reads at `ds_base + si`, then writes the element it read, with upper bytes zero, at `es_base + di`. The accumulator is unchanged.
- R5: When an operation ends, each index it used (source for load and move, destination for store and move) has changed by 1, 2 or 4 bytes, modulo 2^32. It goes up when `cmd_dir`=0 and down when `cmd_dir`=1. An index the operation did not use is unchanged.
- R6: `done` is high for exactly one cycle, in the cycle after the index update. In that cycle the updated indices are already on the outputs and `busy` is low.
- R7: While `mem_req` is high without `mem_ack`, the request stays up with `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` unchanged.
- R8: `start` and `preset` are ignored while `busy` is high. No extra memory access follows, and the registers keep the values of the running operation.
- R9: A `start` with `cmd_op`=3 or `cmd_size`=3 is not accepted. `busy` stays low, no memory request is made, and the registers are unchanged.
- R10: A `preset` pulse while idle loads `si_q`, `di_q` and `acc_q` from `preset_si`, `preset_di` and `preset_acc` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 load, 1 store, 2 move, 3 illegal |
| cmd_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 illegal |
| cmd_dir | input | 1 | 0 step up, 1 step down |
| preset | input | 1 | Register preset strobe, idle only |
| preset_si | input | 32 | Preset value for the source index |
| preset_di | input | 32 | Preset value for the destination index |
| preset_acc | input | 32 | Preset value for the accumulator |
| ds_base | input | 32 | Data segment base |
| es_base | input | 32 | Extra segment base (move destination) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the element |
| mem_be | output | 4 | Valid element bytes, low-aligned |
| mem_wdata | output | 32 | Write data, element right-aligned |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted / data valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_q | output | 32 | Source index |
| di_q | output | 32 | Destination index |
| acc_q | output | 32 | Accumulator |

## Verification
Loads are tried at each of the three sizes, in both directions and with and without wait states. An accumulator preset with distinct bytes shows whether a narrow load disturbs the upper bytes. Stores read back the written address, the data and the enables from a nonzero accumulator, which separates the data base from the extra base and shows whether the upper bytes are masked. Moves use different data and extra bases, so a wrong base selection on either side shows up in the addresses. A downward dword step from index zero exposes a missing wraparound. Stray starts and presets during a long wait, and illegal codes while idle, show whether command acceptance is gated correctly.

// File: rtl/strop_pkg.sv
`timescale 1ns/1ps
package strop_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_MOVE  = 2'd2
  } op_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } state_e;

  // number of bytes in one element
  function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic cmd_legal(input logic [1:0] op, input logic [1:0] sz);
    return (op != 2'd3) && (sz != 2'd3);
  endfunction

  // enables for the low element bytes
  function automatic logic [LANES-1:0] lane_enables(input logic [1:0] sz);
    logic [LANES-1:0] en;
    for (int k = 0; k < LANES; k++) en[k] = (k < int'(elem_bytes(sz)));
    return en;
  endfunction

  // keep the element bytes, clear the rest
  function automatic logic [DATA_W-1:0] keep_elem(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[8*k +: 8] = (k < int'(elem_bytes(sz))) ? d[8*k +: 8] : 8'h00;
    return r;
  endfunction

  // replace the element bytes of old with fresh ones
  function automatic logic [DATA_W-1:0] merge_low(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] fresh,
                                                  input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[8*k +: 8] = (k < int'(elem_bytes(sz))) ? fresh[8*k +: 8] : old[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/strop_seq.sv
`timescale 1ns/1ps
module strop_seq
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cmd_op,
  input  logic [1:0] cmd_size,
  input  logic       cmd_dir,
  input  logic       mem_ack,
  output state_e     state,
  output op_e        op_q,
  output logic [1:0] size_q,
  output logic       dir_q,
  output logic       accept,
  output logic       rd_ack,
  output logic       update,
  output logic       busy,
  output logic       done
);
  state_e state_nx;
  logic   wr_ack;

  assign accept = start && (state == ST_IDLE) && cmd_legal(cmd_op, cmd_size);
  assign rd_ack = (state == ST_RD) && mem_ack;
  assign wr_ack = (state == ST_WR) && mem_ack;
  assign update = (state == ST_UPD);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) state_nx = (op_e'(cmd_op) == OP_STORE) ? ST_WR : ST_RD;
      ST_RD:   if (rd_ack) state_nx = (op_q == OP_MOVE) ? ST_WR : ST_UPD;
      ST_WR:   if (wr_ack) state_nx = ST_UPD;
      ST_UPD:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_LOAD;
      size_q <= SZ_BYTE;
      dir_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= update;
      if (accept) begin
        op_q   <= op_e'(cmd_op);
        size_q <= cmd_size;
        dir_q  <= cmd_dir;
      end
    end
  end
endmodule

// File: rtl/strop_datapath.sv
`timescale 1ns/1ps
module strop_datapath
  import strop_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state,
  input  op_e               op_q,
  input  logic [1:0]        size_q,
  input  logic              dir_q,
  input  logic              rd_ack,
  input  logic              update,
  input  logic              preset,
  input  logic [ADDR_W-1:0] preset_si,
  input  logic [ADDR_W-1:0] preset_di,
  input  logic [DATA_W-1:0] preset_acc,
  input  logic [ADDR_W-1:0] ds_base,
  input  logic [ADDR_W-1:0] es_base,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] si_q,
  output logic [ADDR_W-1:0] di_q,
  output logic [DATA_W-1:0] acc_q
);
  logic [DATA_W-1:0] hold_q;
  logic [ADDR_W-1:0] wr_base;

  function automatic logic [ADDR_W-1:0] step_idx(input logic [ADDR_W-1:0] idx,
                                                 input logic [1:0] sz,
                                                 input logic back);
    logic [ADDR_W-1:0] n;
    n = ADDR_W'(elem_bytes(sz));
    return back ? (idx - n) : (idx + n);
  endfunction

  assign wr_base   = (op_q == OP_MOVE) ? es_base : ds_base;
  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_WR) ? (wr_base + di_q) : (ds_base + si_q);
  assign mem_be    = lane_enables(size_q);
  assign mem_wdata = keep_elem((op_q == OP_MOVE) ? hold_q : acc_q, size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q   <= '0;
      di_q   <= '0;
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      if (preset && (state == ST_IDLE)) begin
        si_q  <= preset_si;
        di_q  <= preset_di;
        acc_q <= preset_acc;
      end
      if (rd_ack) begin
        if (op_q == OP_LOAD) acc_q  <= merge_low(acc_q, mem_rdata, size_q);
        else                 hold_q <= keep_elem(mem_rdata, size_q);
      end
      if (update) begin
        if (op_q != OP_STORE) si_q <= step_idx(si_q, size_q, dir_q);
        if (op_q != OP_LOAD)  di_q <= step_idx(di_q, size_q, dir_q);
      end
    end
  end
endmodule

// File: rtl/strop_engine.sv
`timescale 1ns/1ps
module strop_engine
  import strop_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_dir,
  input  logic              preset,
  input  logic [ADDR_W-1:0] preset_si,
  input  logic [ADDR_W-1:0] preset_di,
  input  logic [31:0]       preset_acc,
  input  logic [ADDR_W-1:0] ds_base,
  input  logic [ADDR_W-1:0] es_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] si_q,
  output logic [ADDR_W-1:0] di_q,
  output logic [31:0]       acc_q
);
  state_e     state;
  op_e        op_q;
  logic [1:0] size_q;
  logic       dir_q;

  // named events for the checker
  logic ev_accept;
  logic ev_rd_ack;
  logic ev_update;

  strop_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_op   (cmd_op),
    .cmd_size (cmd_size),
    .cmd_dir  (cmd_dir),
    .mem_ack  (mem_ack),
    .state    (state),
    .op_q     (op_q),
    .size_q   (size_q),
    .dir_q    (dir_q),
    .accept   (ev_accept),
    .rd_ack   (ev_rd_ack),
    .update   (ev_update),
    .busy     (busy),
    .done     (done)
  );

  strop_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .op_q       (op_q),
    .size_q     (size_q),
    .dir_q      (dir_q),
    .rd_ack     (ev_rd_ack),
    .update     (ev_update),
    .preset     (preset),
    .preset_si  (preset_si),
    .preset_di  (preset_di),
    .preset_acc (preset_acc),
    .ds_base    (ds_base),
    .es_base    (es_base),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .si_q       (si_q),
    .di_q       (di_q),
    .acc_q      (acc_q)
  );
endmodule

// File: rtl/strop_checker.sv
`timescale 1ns/1ps
module strop_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        cmd_op,
  input logic [1:0]        cmd_size,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              ev_accept,
  input logic              ev_update
);
  logic [31:0] be_bits;
  always_comb
    for (int k = 0; k < 4; k++) be_bits[8*k +: 8] = {8{mem_be[k]}};

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_be) && $stable(mem_wdata)); // R7
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111)); // R2
  AST_WDATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ((mem_wdata & ~be_bits) == 32'd0)); // R3
  AST_DONE_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ev_update)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy); // R8
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (cmd_op == 2'd3 || cmd_size == 2'd3) |=> !busy); // R9
endmodule

bind strop_engine strop_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cmd_op    (cmd_op),
  .cmd_size  (cmd_size),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .ev_accept (ev_accept),
  .ev_update (ev_update)
);

// File: tb/strop_engine_test.sv
`timescale 1ns/1ps
module strop_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_size = 2'd0;
  logic        cmd_dir = 1'b0;
  logic        preset = 1'b0;
  logic [31:0] preset_si = 32'd0, preset_di = 32'd0, preset_acc = 32'd0;
  logic [31:0] ds_base = 32'h1000_0000;
  logic [31:0] es_base = 32'h2000_0080;
  logic        mem_req, mem_we, mem_ack, busy, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, si_q, di_q, acc_q;
  logic [3:0]  mem_be;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  strop_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_size(cmd_size),
    .cmd_dir(cmd_dir), .preset(preset), .preset_si(preset_si), .preset_di(preset_di),
    .preset_acc(preset_acc), .ds_base(ds_base), .es_base(es_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .done(done), .si_q(si_q), .di_q(di_q), .acc_q(acc_q)
  );

  // memory model: 256 bytes on address bits 7:0, programmable wait states
  logic [7:0]  mem [256];
  int          wait_n = 0;
  int          wcnt = 0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] last_rd_addr = 32'd0, last_wr_addr = 32'd0, last_wr_data = 32'd0;
  logic [3:0]  last_rd_be = 4'd0, last_wr_be = 4'd0;
  logic        hold_armed = 1'b0, hold_err = 1'b0;
  logic [31:0] hold_addr = 32'd0, hold_data = 32'd0;
  logic [3:0]  hold_be = 4'd0;
  logic        hold_we = 1'b0;
  logic [7:0]  ma;

  assign ma        = mem_addr[7:0];
  assign mem_ack   = mem_req && (wcnt >= wait_n);
  assign mem_rdata = {mem[ma + 8'd3], mem[ma + 8'd2], mem[ma + 8'd1], mem[ma]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= 8'(k) ^ 8'h5A;
      wcnt <= 0;
      hold_armed <= 1'b0;
    end else begin
      if (hold_armed && (!mem_req || mem_addr != hold_addr || mem_we != hold_we
                         || mem_be != hold_be || mem_wdata != hold_data))
        hold_err <= 1'b1;
      hold_armed <= mem_req && !mem_ack;
      hold_addr  <= mem_addr;
      hold_we    <= mem_we;
      hold_be    <= mem_be;
      hold_data  <= mem_wdata;
      if (mem_req && !mem_ack) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[ma + 8'(k)] <= mem_wdata[8*k +: 8];
          n_wr <= n_wr + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
          last_wr_be   <= mem_be;
        end else begin
          n_rd <= n_rd + 1;
          last_rd_addr <= mem_addr;
          last_rd_be   <= mem_be;
        end
      end
    end
  end

  // bench arithmetic from the requirements
  function automatic logic [31:0] szmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] exp_be(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h1 : (sz == 2'd1) ? 32'h3 : 32'hF;
  endfunction
  function automatic logic [31:0] nxt(input logic [31:0] idx, input logic [1:0] sz,
                                      input logic d);
    logic [31:0] n;
    n = 32'd1 << sz;
    return d ? idx - n : idx + n;
  endfunction
  function automatic logic [31:0] peek(input logic [31:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {mem[b + 8'd3], mem[b + 8'd2], mem[b + 8'd1], mem[b]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_preset(input logic [31:0] s, input logic [31:0] d, input logic [31:0] a);
    @(negedge clk);
    preset = 1'b1; preset_si = s; preset_di = d; preset_acc = a;
    @(negedge clk);
    preset = 1'b0;
  endtask

  // issue one command, wait for done, check the done pulse shape (R6)
  task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic d);
    int guard;
    @(negedge clk);
    cmd_op = op; cmd_size = sz; cmd_dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R6 done seen", {31'd0, done}, 32'd1);
    check("R6 idle at done", {31'd0, busy}, 32'd0);
  endtask

  task automatic after_done_pulse();
    @(negedge clk);
    check("R6 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 si", si_q, 32'd0);
    check("R1 di", di_q, 32'd0);
    check("R1 acc", acc_q, 32'd0);
    check("R1 busy/done/req", {29'd0, busy, done, mem_req}, 32'd0);
  endtask

  task automatic t_preset();
    do_preset(32'h0000_0010, 32'h0000_0040, 32'h1122_3344);
    check("R10 si", si_q, 32'h0000_0010);
    check("R10 di", di_q, 32'h0000_0040);
    check("R10 acc", acc_q, 32'h1122_3344);
  endtask

  task automatic t_load(input logic [1:0] sz, input logic d, input int w);
    logic [31:0] s0, d0, a0, src, ea;
    wait_n = w;
    s0 = si_q; d0 = di_q; a0 = acc_q;
    src = ds_base + s0;
    ea  = (a0 & ~szmask(sz)) | (peek(src) & szmask(sz));
    run_op(2'd0, sz, d);
    check("R2 load addr", last_rd_addr, src);
    check("R2 load be", {28'd0, last_rd_be}, exp_be(sz));
    check("R2 load acc", acc_q, ea);
    check("R5 load si", si_q, nxt(s0, sz, d));
    check("R5 load di kept", di_q, d0);
    after_done_pulse();
  endtask

  task automatic t_store(input logic [1:0] sz, input logic d, input int w);
    logic [31:0] s0, d0, a0, dst;
    wait_n = w;
    s0 = si_q; d0 = di_q; a0 = acc_q;
    dst = ds_base + d0;
    run_op(2'd1, sz, d);
    check("R3 store addr", last_wr_addr, dst);
    check("R3 store data", last_wr_data, a0 & szmask(sz));
    check("R3 store be", {28'd0, last_wr_be}, exp_be(sz));
    check("R3 store acc kept", acc_q, a0);
    check("R5 store di", di_q, nxt(d0, sz, d));
    check("R5 store si kept", si_q, s0);
    after_done_pulse();
  endtask

  task automatic t_move(input logic [1:0] sz, input logic d, input int w);
    logic [31:0] s0, d0, a0, src, dst, el;
    int r0, w0;
    wait_n = w;
    s0 = si_q; d0 = di_q; a0 = acc_q;
    src = ds_base + s0; dst = es_base + d0;
    el = peek(src) & szmask(sz);
    r0 = n_rd; w0 = n_wr;
    run_op(2'd2, sz, d);
    check("R4 move rd addr", last_rd_addr, src);
    check("R4 move wr addr", last_wr_addr, dst);
    check("R4 move data", last_wr_data, el);
    check("R4 move acc kept", acc_q, a0);
    check("R4 move one rd one wr", 32'(n_rd - r0) << 4 | 32'(n_wr - w0), 32'h11);
    check("R5 move si", si_q, nxt(s0, sz, d));
    check("R5 move di", di_q, nxt(d0, sz, d));
    after_done_pulse();
  endtask

  task automatic t_wrap();
    do_preset(32'd0, 32'd3, 32'hCAFE_F00D);
    t_load(2'd2, 1'b1, 0);
    check("R5 wrap si", si_q, 32'hFFFF_FFFC);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] s0, d0, a0;
    int w0;
    do_preset(32'h0000_0020, 32'h0000_0050, 32'h0BAD_BEEF);
    s0 = si_q; d0 = di_q; a0 = acc_q;
    w0 = n_wr;
    wait_n = 6;
    @(negedge clk);
    cmd_op = 2'd2; cmd_size = 2'd1; cmd_dir = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    cmd_op = 2'd1; cmd_size = 2'd2; start = 1'b1;
    preset = 1'b1; preset_si = 32'h77; preset_di = 32'h66; preset_acc = 32'h55;
    @(negedge clk);
    start = 1'b0; preset = 1'b0;
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R8 busy after", {31'd0, busy}, 32'd0);
    check("R8 one write", 32'(n_wr - w0), 32'd1);
    check("R8 si", si_q, s0 + 32'd2);
    check("R8 di", di_q, d0 + 32'd2);
    check("R8 acc", acc_q, a0);
    check("R7 request held", {31'd0, hold_err}, 32'd0);
  endtask

  task automatic t_illegal();
    logic [31:0] s0, d0, a0;
    int r0, w0;
    s0 = si_q; d0 = di_q; a0 = acc_q;
    r0 = n_rd; w0 = n_wr;
    wait_n = 0;
    @(negedge clk);
    cmd_op = 2'd3; cmd_size = 2'd0; start = 1'b1;
    @(negedge clk);
    check("R9 op3 busy", {31'd0, busy}, 32'd0);
    cmd_op = 2'd0; cmd_size = 2'd3;
    @(negedge clk);
    check("R9 size3 busy", {31'd0, busy}, 32'd0);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no access", 32'(n_rd - r0) + 32'(n_wr - w0), 32'd0);
    check("R9 regs", si_q ^ d0 ^ acc_q, s0 ^ di_q ^ a0);
    check("R9 si", si_q, s0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preset();
    t_load(2'd0, 1'b0, 0);
    t_load(2'd1, 1'b1, 0);
    t_load(2'd2, 1'b0, 3);
    t_store(2'd0, 1'b0, 0);
    t_store(2'd2, 1'b1, 2);
    t_store(2'd1, 1'b0, 0);
    t_move(2'd1, 1'b0, 0);
    t_move(2'd2, 1'b1, 4);
    t_move(2'd0, 1'b0, 1);
    t_wrap();
    t_busy_ignore();
    t_illegal();
    check("R7 request held", {31'd0, hold_err}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule